// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the configuration of a set of hardware match triggers for a core's debug support. Software reaches it through three control-register addresses: a selector, a control word and a compare value. The selector chooses which trigger the other two addresses act on. A fourth trigger-data address is decoded and always reads zero. Every other address also reads zero.

Each trigger stores its control fields and a 32-bit compare value. A trigger whose debug-only bit is set can be rewritten only while the core is in debug mode. The bank also drives three summary flags that tell the memory pipeline whether any trigger watches instruction fetches, loads or stores. The comparators themselves sit elsewhere and are not part of this block.

Reads are combinational from the address. Writes take effect on the rising clock edge.

Top module: `dbg_trig_bank`

## Requirements
- R1: After reset the selector reads 0. Every trigger's control word reads 0x2000_0000: kind field [31:28] = 2 and all other fields 0. Every compare value reads 0, and all three watch flags are 0.
- R2: A selector write is accepted only when the written 32-bit value is below NUM_TRIG. Otherwise the selector keeps its old value.
- R3: The control-word layout is kind[31:28], debug-only[27], mask limit[26:21], bit 20 reserved and read as 0, select[19], timing[18], action[17:12], chain[11], match[10:7], m[6], h[5], s[4], u[3], execute[2], store[1], load[0]. A write updates bit 27 and bits 19:0. The kind and mask-limit fields ignore writes.
- R4: When an accepted control write has execute (bit 2) set, the stored timing bit reads 0 whatever value was written. When execute is clear, timing keeps the value written.
- R5: When the selected trigger has its debug-only bit set and in_debug is 0, writes to its control word and to its compare value are dropped. With in_debug at 1 the same writes are accepted.
- R6: Each trigger keeps its own 32-bit compare value, and the selector decides which one is written and read.
- R7: Reads of the third trigger-data address, and of any address outside the decoded set, return 0.
- R8: From the cycle after any accepted control write, watch_fetch, watch_load and watch_store are the OR across all triggers of the execute, load and store bits respectively.
- R9: The mask-limit field reads the MASKMAX parameter value, which is 0 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | Register address |
| csr_we | input | 1 | Write strobe, sampled on the rising edge |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| in_debug | input | 1 | Core is in debug mode |
| watch_fetch | output | 1 | Some trigger has execute set |
| watch_load | output | 1 | Some trigger has load set |
| watch_store | output | 1 | Some trigger has store set |

## Verification
The lock check and the execute-forces-timing rule both act on the same control write. A single write therefore has to be either dropped whole or stored with timing cleared, and the summary flags must follow it on the next cycle.

The bench provokes this in two ways. Random control words are written with the debug-only and execute bits set together, and in_debug is toggled between writes. Each case is judged by reading the word back and by comparing the flags against a bench model. That model applies the lock before the timing rule.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  localparam logic [3:0] TRIG_KIND_MATCH = 4'd2;

  typedef struct packed {
    logic       dmode;
    logic       sel;
    logic       timing;
    logic [5:0] action;
    logic       chain;
    logic [3:0] match;
    logic       m;
    logic       h;
    logic       s;
    logic       u;
    logic       exec;
    logic       store;
    logic       load;
  } trig_ctrl_t;

  localparam int CTRL_W = $bits(trig_ctrl_t);

  // timing is meaningless for fetch matches and is pinned to "before"
  function automatic logic timing_rule(input logic exec, input logic timing);
    return timing & ~exec;
  endfunction

  function automatic trig_ctrl_t ctrl_decode(input logic [31:0] w);
    trig_ctrl_t c;
    c.dmode  = w[27];
    c.sel    = w[19];
    c.timing = timing_rule(w[2], w[18]);
    c.action = w[17:12];
    c.chain  = w[11];
    c.match  = w[10:7];
    c.m      = w[6];
    c.h      = w[5];
    c.s      = w[4];
    c.u      = w[3];
    c.exec   = w[2];
    c.store  = w[1];
    c.load   = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_encode(input trig_ctrl_t c, input logic [5:0] maskmax);
    return {TRIG_KIND_MATCH, c.dmode, maskmax, 1'b0, c.sel, c.timing, c.action,
            c.chain, c.match, c.m, c.h, c.s, c.u, c.exec, c.store, c.load};
  endfunction

endpackage

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
  import dbg_trig_pkg::*;
#(
  parameter logic [5:0] MASKMAX = 6'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_debug,
  input  logic       ctrl_we,
  input  logic       data_we,
  input  logic [31:0] wdata,
  output trig_ctrl_t ctrl_q,
  output logic [31:0] data_q,
  output logic       locked,
  output logic [31:0] ctrl_word
);

  logic ctrl_take;
  logic data_take;

  assign locked    = ctrl_q.dmode & ~in_debug;
  assign ctrl_take = ctrl_we & ~locked;
  assign data_take = data_we & ~locked;
  assign ctrl_word = ctrl_encode(ctrl_q, MASKMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_take) ctrl_q <= ctrl_decode(wdata);
      if (data_take) data_q <= wdata;
    end
  end

endmodule

// File: rtl/dbg_trig_watch.sv
module dbg_trig_watch #(
  parameter int NUM_TRIG = 4
) (
  input  logic [NUM_TRIG-1:0] exec_vec,
  input  logic [NUM_TRIG-1:0] load_vec,
  input  logic [NUM_TRIG-1:0] store_vec,
  output logic                watch_fetch,
  output logic                watch_load,
  output logic                watch_store
);

  assign watch_fetch = |exec_vec;
  assign watch_load  = |load_vec;
  assign watch_store = |store_vec;

endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
  import dbg_trig_pkg::*;
#(
  parameter int          NUM_TRIG  = 4,
  parameter int          MASKMAX   = 0,
  parameter logic [11:0] ADDR_SEL  = 12'h7A0,
  parameter logic [11:0] ADDR_CTRL = 12'h7A1,
  parameter logic [11:0] ADDR_CMP  = 12'h7A2,
  parameter logic [11:0] ADDR_AUX  = 12'h7A3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        in_debug,
  output logic        watch_fetch,
  output logic        watch_load,
  output logic        watch_store
);

  localparam int          SEL_W     = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam logic [31:0] NT32      = 32'(NUM_TRIG);
  localparam logic [5:0]  MASKMAX_F = 6'(MASKMAX);
  localparam int          STATE_W   = NUM_TRIG * (CTRL_W + 32);

  logic [SEL_W-1:0]    sel_q;
  logic [31:0]         sel_word;
  logic                sel_ok;
  logic [NUM_TRIG-1:0] sel_onehot;

  logic hit_sel, hit_ctrl, hit_cmp;
  logic sel_wr_take;

  trig_ctrl_t          ctrl_arr [NUM_TRIG];
  logic [31:0]         data_arr [NUM_TRIG];
  logic [31:0]         word_arr [NUM_TRIG];
  logic [NUM_TRIG-1:0] locked_vec;
  logic [NUM_TRIG-1:0] exec_vec, load_vec, store_vec, timing_vec;
  logic [STATE_W-1:0]  state_flat;

  logic        locked_sel;
  logic        ctrl_wr_drop;
  logic [31:0] ctrl_rd, cmp_rd;

  assign hit_sel  = (csr_addr == ADDR_SEL);
  assign hit_ctrl = (csr_addr == ADDR_CTRL);
  assign hit_cmp  = (csr_addr == ADDR_CMP);

  assign sel_word    = 32'(sel_q);
  assign sel_ok      = (sel_word < NT32);
  assign sel_wr_take = csr_we & hit_sel & (csr_wdata < NT32);

  always_comb begin
    for (int i = 0; i < NUM_TRIG; i++) begin
      sel_onehot[i] = sel_ok & (sel_word == 32'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_wr_take) begin
      sel_q <= csr_wdata[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
    dbg_trig_slot #(.MASKMAX(MASKMAX_F)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_debug (in_debug),
      .ctrl_we  (csr_we & hit_ctrl & sel_onehot[i]),
      .data_we  (csr_we & hit_cmp & sel_onehot[i]),
      .wdata    (csr_wdata),
      .ctrl_q   (ctrl_arr[i]),
      .data_q   (data_arr[i]),
      .locked   (locked_vec[i]),
      .ctrl_word(word_arr[i])
    );
    assign exec_vec[i]   = ctrl_arr[i].exec;
    assign load_vec[i]   = ctrl_arr[i].load;
    assign store_vec[i]  = ctrl_arr[i].store;
    assign timing_vec[i] = ctrl_arr[i].timing;
    assign state_flat[i*(CTRL_W+32) +: (CTRL_W+32)] = {ctrl_arr[i], data_arr[i]};
  end

  assign locked_sel   = |(sel_onehot & locked_vec);
  assign ctrl_wr_drop = csr_we & (hit_ctrl | hit_cmp) & locked_sel;

  always_comb begin
    ctrl_rd = '0;
    cmp_rd  = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (sel_onehot[i]) begin
        ctrl_rd = ctrl_rd | word_arr[i];
        cmp_rd  = cmp_rd | data_arr[i];
      end
    end
  end

  always_comb begin
    if (hit_sel)       csr_rdata = sel_word;
    else if (hit_ctrl) csr_rdata = ctrl_rd;
    else if (hit_cmp)  csr_rdata = cmp_rd;
    else               csr_rdata = '0;
  end

  dbg_trig_watch #(.NUM_TRIG(NUM_TRIG)) u_watch (
    .exec_vec   (exec_vec),
    .load_vec   (load_vec),
    .store_vec  (store_vec),
    .watch_fetch(watch_fetch),
    .watch_load (watch_load),
    .watch_store(watch_store)
  );

endmodule

// File: rtl/dbg_trig_bank_chk.sv
module dbg_trig_bank_chk #(
  parameter int          NUM_TRIG  = 4,
  parameter int          STATE_W   = 4,
  parameter int          SEL_W     = 2,
  parameter int          MASKMAX   = 0,
  parameter logic [11:0] ADDR_SEL  = 12'h7A0,
  parameter logic [11:0] ADDR_CTRL = 12'h7A1,
  parameter logic [11:0] ADDR_AUX  = 12'h7A3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [11:0]         csr_addr,
  input logic                csr_we,
  input logic [31:0]         csr_wdata,
  input logic [31:0]         csr_rdata,
  input logic                watch_fetch,
  input logic [SEL_W-1:0]    sel_q,
  input logic [NUM_TRIG-1:0] exec_vec,
  input logic [NUM_TRIG-1:0] timing_vec,
  input logic                locked_sel,
  input logic                ctrl_wr_drop,
  input logic [STATE_W-1:0]  state_flat
);

  assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < 32'(NUM_TRIG));

  assert_sel_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == ADDR_SEL && csr_wdata >= 32'(NUM_TRIG)) |=> $stable(sel_q));

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_tim
    assert_timing_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_vec[i] && timing_vec[i]));
  end

  assert_locked_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_drop |=> $stable(state_flat));

  assert_aux_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_AUX) |-> (csr_rdata == 32'd0));

  assert_fetch_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == ADDR_CTRL && !locked_sel && csr_wdata[2]) |=> watch_fetch);

  assert_fixed_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_CTRL) |->
      (csr_rdata[31:28] == 4'd2 && csr_rdata[26:21] == 6'(MASKMAX) && !csr_rdata[20]));

endmodule

bind dbg_trig_bank dbg_trig_bank_chk #(
  .NUM_TRIG (NUM_TRIG),
  .STATE_W  (STATE_W),
  .SEL_W    (SEL_W),
  .MASKMAX  (MASKMAX),
  .ADDR_SEL (ADDR_SEL),
  .ADDR_CTRL(ADDR_CTRL),
  .ADDR_AUX (ADDR_AUX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_addr    (csr_addr),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .watch_fetch (watch_fetch),
  .sel_q       (sel_q),
  .exec_vec    (exec_vec),
  .timing_vec  (timing_vec),
  .locked_sel  (locked_sel),
  .ctrl_wr_drop(ctrl_wr_drop),
  .state_flat  (state_flat)
);

// File: tb/test_dbg_trig_bank.sv
`timescale 1ns/1ps
module test_dbg_trig_bank;

  localparam int          NT   = 4;
  localparam logic [11:0] A_SEL = 12'h7A0;
  localparam logic [11:0] A_CTL = 12'h7A1;
  localparam logic [11:0] A_CMP = 12'h7A2;
  localparam logic [11:0] A_AUX = 12'h7A3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        in_debug = 1'b0;
  logic        watch_fetch, watch_load, watch_store;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ctl [NT];
  logic [31:0] m_cmp [NT];
  int          m_sel;

  always #4 clk = ~clk;

  dbg_trig_bank #(.NUM_TRIG(NT)) i_dbg_trig_bank (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .in_debug(in_debug),
    .watch_fetch(watch_fetch), .watch_load(watch_load), .watch_store(watch_store)
  );

  // expected stored word after a control write (lock handled by caller)
  function automatic logic [31:0] ctl_after(input logic [31:0] w);
    logic [31:0] r;
    r = (w & 32'h080F_FFFF) | 32'h2000_0000;
    if (w[2]) r[18] = 1'b0;
    return r;
  endfunction

  function automatic logic [2:0] flags_exp();
    logic [2:0] f = 3'b000;
    for (int i = 0; i < NT; i++) begin
      f[2] = f[2] | m_ctl[i][2];
      f[1] = f[1] | m_ctl[i][0];
      f[0] = f[0] | m_ctl[i][1];
    end
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    csr_addr = a;
    csr_we = 1'b0;
    #1;
    v = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic locked;
    @(negedge clk);
    csr_addr = a;
    csr_wdata = d;
    csr_we = 1'b1;
    locked = m_ctl[m_sel][27] && !in_debug;
    @(negedge clk);
    csr_we = 1'b0;
    if (a == A_SEL && d < NT) m_sel = int'(d);
    if (a == A_CTL && !locked) m_ctl[m_sel] = ctl_after(d);
    if (a == A_CMP && !locked) m_cmp[m_sel] = d;
  endtask

  task automatic chk_flags(input string req);
    #1;
    check(req, {29'd0, watch_fetch, watch_load, watch_store}, {29'd0, flags_exp()});
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    for (int i = 0; i < NT; i++) begin
      m_ctl[i] = 32'h2000_0000;
      m_cmp[i] = 32'd0;
    end
    m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_flags("R1 flags");
    rd(A_SEL, v); check("R1 sel", v, 32'd0);
    for (int i = 0; i < NT; i++) begin
      wr(A_SEL, 32'(i));
      rd(A_CTL, v); check("R1 ctrl", v, 32'h2000_0000);
      rd(A_CMP, v); check("R1 cmp", v, 32'd0);
    end

    // R2 selector rejection
    wr(A_SEL, 32'd1);
    wr(A_SEL, 32'd4);          rd(A_SEL, v); check("R2 sel=4", v, 32'd1);
    wr(A_SEL, 32'hFFFF_FFFF);  rd(A_SEL, v); check("R2 sel=all1", v, 32'd1);
    wr(A_SEL, 32'd3);          rd(A_SEL, v); check("R2 sel=3", v, 32'd3);

    // R3 R4 R9 all-ones write in debug mode
    in_debug = 1'b1;
    wr(A_SEL, 32'd0);
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); check("R3 R4 R9 all ones", v, 32'h280B_FFFF);
    wr(A_CTL, 32'h0804_0000); rd(A_CTL, v); check("R4 timing kept", v, 32'h2804_0000);

    // R5 lock outside debug mode
    in_debug = 1'b0;
    wr(A_CTL, 32'h0000_0007); rd(A_CTL, v); check("R5 ctrl dropped", v, 32'h2804_0000);
    wr(A_CMP, 32'hDEAD_BEEF); rd(A_CMP, v); check("R5 cmp dropped", v, 32'd0);
    chk_flags("R5 flags unchanged");
    in_debug = 1'b1;
    wr(A_CMP, 32'hCAFE_0001); rd(A_CMP, v); check("R5 cmp in debug", v, 32'hCAFE_0001);
    wr(A_CTL, 32'd0);         rd(A_CTL, v); check("R5 ctrl in debug", v, 32'h2000_0000);
    in_debug = 1'b0;

    // R6 separate compare values
    wr(A_SEL, 32'd2); wr(A_CMP, 32'h0000_2222);
    wr(A_SEL, 32'd0); rd(A_CMP, v); check("R6 slot0", v, 32'hCAFE_0001);
    wr(A_SEL, 32'd2); rd(A_CMP, v); check("R6 slot2", v, 32'h0000_2222);

    // R7 unused addresses
    rd(A_AUX, v);   check("R7 aux", v, 32'd0);
    rd(12'h123, v); check("R7 unmapped", v, 32'd0);

    // R8 watch flags
    wr(A_CTL, 32'h0000_0004); chk_flags("R8 fetch only");
    wr(A_SEL, 32'd3); wr(A_CTL, 32'h0000_0003); chk_flags("R8 load store");
    wr(A_SEL, 32'd2); wr(A_CTL, 32'd0); chk_flags("R8 fetch cleared");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 5));
      d = $urandom;
      case (op)
        0: wr(A_SEL, 32'($urandom_range(0, 7)));
        1: wr(A_CTL, d);
        2: wr(A_CMP, d);
        3: in_debug = ~in_debug;
        4: begin rd(A_CTL, v); check("R3 R5 rand ctrl", v, m_ctl[m_sel]); end
        default: begin rd(A_CMP, v); check("R6 rand cmp", v, m_cmp[m_sel]); end
      endcase
      if (n % 8 == 0) begin
        rd(A_SEL, v); check("R2 rand sel", v, 32'(m_sel));
        chk_flags("R8 rand flags");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule